// File: doc/BRIEF.md
# Always-On Wake Source Aggregator

This block gathers every wake event of the always-on domain onto one request line for a parent interrupt controller. It has three kinds of source, and each kind has its own control layout. Two dedicated edge lines have their controls packed into small shared registers. A bank of general-purpose pin lines, also edge-sensitive, has one control word per pin. A group of level lines has a byte-wide mask register and a byte-wide polarity register. Edge events are latched as pending until software clears them. Level lines are qualified and passed straight through.

The block exposes the qualified source vector as two 16-bit status halves. A priority encoder picks out the lowest-numbered active source and flags when one exists. A handler can therefore service sources in ascending index order without scanning the status itself. Each edge source has a small two-state machine. `CELL_IDLE` moves to `CELL_PEND` on the selected edge, the *arm* transition. `CELL_PEND` goes back to `CELL_IDLE` on a write-1 clear when no new edge arrives in the same cycle, the *release* transition. Every other combination holds the present state.

Source numbering: index 0 and index 1 are the dedicated lines. Index 2+p is general-purpose pin p. Index NUM_DED+NUM_GPIO+j is level line j. Configuration uses a write-only port with 8-bit byte addresses and 16-bit data. Each write takes effect at the clock edge that samples it.

Top module: `wk_cascade`

## Requirements
- R1: After reset every source is masked, no edge is pending, all edges are rising, and all level polarities are active-high. The status reads zero, and `wake_req` and `first_vld` are low, even while level inputs are high.
- R2: Dedicated sources 0 and 1 are controlled through three registers, each using bits [1:0]. The mask register is at address 0x00, where 1 means masked. The edge-select register is at 0x04, where 1 means falling and 0 means rising. The write-1 clear register is at 0x08.
- R3: General-purpose pin p (source 2+p) is controlled by the word at address 0x40+4·p. Bit 4 is the mask (1 = masked), bit 6 is a write-1 clear, and bit 7 selects the falling edge (0 = rising).
- R4: An edge source's pending flag sets at the first clock edge that sees the selected transition on its input. It stays set until cleared. It is captured even while the source is masked. The mask only hides the flag from the status.
- R5: A clear written in the same cycle as a new selected edge leaves the source pending.
- R6: Level source j is controlled by mask bit j at address 0x0C and polarity bit j at address 0x10, where polarity 1 means active-low. Its status bit is (input XOR polarity) AND NOT mask, taken from the input in the same cycle without latching.
- R7: `stat_lo` carries status bits 15..0 and `stat_hi` carries bits 31..16. Status bit i is the qualified state of source i, and unused upper bits read zero.
- R8: `wake_req` is high exactly when at least one status bit is set.
- R9: `first_idx` gives the lowest set status bit and `first_vld` shows that one exists, both in the same cycle as the status. `first_idx` reads 0 when nothing is set.
- R10: Whenever `wake_req` is high, `first_vld` is high too, so a request never comes with an empty status.
- R11: The block ignores the following: writes to any other address, a transition opposite to the selected edge, and a pending edge flag that stays set for lack of a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ded_src | input | 2 | Dedicated wake lines (sources 0 and 1) |
| gpio_src | input | NUM_GPIO | General-purpose pin wake lines |
| lvl_src | input | NUM_LVL | Level-type wake lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 16 | Configuration write data |
| wake_req | output | 1 | Combined request to the parent controller |
| stat_lo | output | 16 | Status bits 15..0 |
| stat_hi | output | 16 | Status bits 31..16 |
| first_idx | output | 5 | Lowest active source index |
| first_vld | output | 1 | An active source exists |

## Verification
Suppose an edge cell's state machine is stuck in or wrongly enters `CELL_PEND`. The fault shows up in the status on the clock edge that follows the offending stimulus or clear, and `first_idx` changes with it whenever that source is the lowest one active. A wrong mask, polarity or edge-select register shows up one edge after the write that should have set it. For a level line it shows on the very next status sample, and for an edge line on the first transition afterwards. A fault in the encoder shows up in the same cycle as the status that exposes it, as an index that is not the lowest set bit.

// File: rtl/wk_pkg.sv
`timescale 1ns/1ps
package wk_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 16;
    localparam int HALF_W    = 16;
    localparam int STAT_W    = 2 * HALF_W;
    localparam int IDX_W     = $clog2(STAT_W);
    localparam int NUM_DED   = 2;

    localparam logic [ADDR_W-1:0] ADR_DED_MASK = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_DED_EDGE = 8'h04;
    localparam logic [ADDR_W-1:0] ADR_DED_CLR  = 8'h08;
    localparam logic [ADDR_W-1:0] ADR_LVL_MASK = 8'h0C;
    localparam logic [ADDR_W-1:0] ADR_LVL_POL  = 8'h10;
    localparam int                ADR_PIN_BASE = 'h40;
    localparam int                PIN_STRIDE   = 4;

    localparam int PIN_MASK_BIT = 4;
    localparam int PIN_CLR_BIT  = 6;
    localparam int PIN_FALL_BIT = 7;

    typedef enum logic {
        CELL_IDLE = 1'b0,
        CELL_PEND = 1'b1
    } cell_state_e;
endpackage

// File: rtl/wk_edge_cell.sv
`timescale 1ns/1ps
module wk_edge_cell
    import wk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic fall_sel,
    input  logic clr,
    output logic pend
);
    cell_state_e state_q, state_d;
    logic        prev_q;
    logic        hit;

    assign hit = fall_sel ? (prev_q & ~src) : (~prev_q & src);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CELL_IDLE;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= src;
        end
    end

    // transitions: arm on edge, release on clear unless a new edge arrives
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_IDLE: if (hit)         state_d = CELL_PEND;
            CELL_PEND: if (clr && !hit) state_d = CELL_IDLE;
            default:                    state_d = CELL_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pend = (state_q == CELL_PEND);
    end
endmodule

// File: rtl/wk_prio_enc.sv
`timescale 1ns/1ps
module wk_prio_enc #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          vld
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        vld = |vec;
    end
endmodule

// File: rtl/wk_cfg.sv
`timescale 1ns/1ps
module wk_cfg
    import wk_pkg::*;
#(
    parameter int NUM_GPIO = 22,
    parameter int NUM_LVL  = 8,
    parameter int NEDGE    = NUM_DED + NUM_GPIO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [NEDGE-1:0]  edge_mask,
    output logic [NEDGE-1:0]  edge_fall,
    output logic [NEDGE-1:0]  edge_clr,
    output logic [NUM_LVL-1:0] lvl_mask,
    output logic [NUM_LVL-1:0] lvl_pol
);
    logic [NUM_DED-1:0] ded_mask_q, ded_fall_q, ded_clr;
    logic [NUM_LVL-1:0] lvl_mask_q, lvl_pol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ded_mask_q <= '1;
            ded_fall_q <= '0;
            lvl_mask_q <= '1;
            lvl_pol_q  <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                ADR_DED_MASK: ded_mask_q <= cfg_wdata[NUM_DED-1:0];
                ADR_DED_EDGE: ded_fall_q <= cfg_wdata[NUM_DED-1:0];
                ADR_LVL_MASK: lvl_mask_q <= cfg_wdata[NUM_LVL-1:0];
                ADR_LVL_POL:  lvl_pol_q  <= cfg_wdata[NUM_LVL-1:0];
                default: ;
            endcase
        end
    end

    assign ded_clr = (cfg_we && cfg_addr == ADR_DED_CLR) ? cfg_wdata[NUM_DED-1:0] : '0;

    assign edge_mask[NUM_DED-1:0] = ded_mask_q;
    assign edge_fall[NUM_DED-1:0] = ded_fall_q;
    assign edge_clr[NUM_DED-1:0]  = ded_clr;

    for (genvar p = 0; p < NUM_GPIO; p++) begin : g_pin
        localparam logic [ADDR_W-1:0] PIN_ADR = ADDR_W'(ADR_PIN_BASE + PIN_STRIDE * p);
        logic pin_hit;
        logic mask_q, fall_q;

        assign pin_hit = cfg_we && (cfg_addr == PIN_ADR);

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q <= 1'b1;
                fall_q <= 1'b0;
            end else if (pin_hit) begin
                mask_q <= cfg_wdata[PIN_MASK_BIT];
                fall_q <= cfg_wdata[PIN_FALL_BIT];
            end
        end

        assign edge_mask[NUM_DED+p] = mask_q;
        assign edge_fall[NUM_DED+p] = fall_q;
        assign edge_clr[NUM_DED+p]  = pin_hit & cfg_wdata[PIN_CLR_BIT];
    end

    assign lvl_mask = lvl_mask_q;
    assign lvl_pol  = lvl_pol_q;
endmodule

// File: rtl/wk_cascade.sv
`timescale 1ns/1ps
module wk_cascade
    import wk_pkg::*;
#(
    parameter int NUM_GPIO = 22,
    parameter int NUM_LVL  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          ded_src,
    input  logic [NUM_GPIO-1:0] gpio_src,
    input  logic [NUM_LVL-1:0]  lvl_src,
    input  logic                cfg_we,
    input  logic [7:0]          cfg_addr,
    input  logic [15:0]         cfg_wdata,
    output logic                wake_req,
    output logic [15:0]         stat_lo,
    output logic [15:0]         stat_hi,
    output logic [4:0]          first_idx,
    output logic                first_vld
);
    localparam int NEDGE = NUM_DED + NUM_GPIO;
    localparam int NSRC  = NEDGE + NUM_LVL;

    logic [NEDGE-1:0]   edge_src, edge_mask_w, edge_fall_w, edge_clr_w, edge_pend;
    logic [NUM_LVL-1:0] lvl_mask_w, lvl_pol_w;
    logic [STAT_W-1:0]  stat_vec;
    logic [IDX_W-1:0]   enc_idx;
    logic               enc_vld;

    assign edge_src = {gpio_src, ded_src};

    wk_cfg #(
        .NUM_GPIO (NUM_GPIO),
        .NUM_LVL  (NUM_LVL),
        .NEDGE    (NEDGE)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .edge_mask (edge_mask_w),
        .edge_fall (edge_fall_w),
        .edge_clr  (edge_clr_w),
        .lvl_mask  (lvl_mask_w),
        .lvl_pol   (lvl_pol_w)
    );

    for (genvar i = 0; i < NEDGE; i++) begin : g_edge
        wk_edge_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .src      (edge_src[i]),
            .fall_sel (edge_fall_w[i]),
            .clr      (edge_clr_w[i]),
            .pend     (edge_pend[i])
        );
        assign stat_vec[i] = edge_pend[i] & ~edge_mask_w[i];
    end

    for (genvar j = 0; j < NUM_LVL; j++) begin : g_lvl
        assign stat_vec[NEDGE+j] = (lvl_src[j] ^ lvl_pol_w[j]) & ~lvl_mask_w[j];
    end

    if (NSRC < STAT_W) begin : g_pad
        assign stat_vec[STAT_W-1:NSRC] = '0;
    end

    wk_prio_enc #(
        .W  (STAT_W),
        .IW (IDX_W)
    ) u_enc (
        .vec (stat_vec),
        .idx (enc_idx),
        .vld (enc_vld)
    );

    assign stat_lo   = stat_vec[HALF_W-1:0];
    assign stat_hi   = stat_vec[STAT_W-1:HALF_W];
    assign wake_req  = |stat_vec;
    assign first_idx = enc_idx;
    assign first_vld = enc_vld;
endmodule

// File: rtl/wk_cascade_chk.sv
`timescale 1ns/1ps
module wk_cascade_chk #(
    parameter int NUM_GPIO = 22
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic        wake_req,
    input logic [15:0] stat_lo,
    input logic [15:0] stat_hi,
    input logic [4:0]  first_idx,
    input logic        first_vld
);
    localparam int NEDGE = 2 + NUM_GPIO;
    logic [31:0] st;
    assign st = {stat_hi, stat_lo};

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st == 32'd0 && !wake_req && !first_vld));

    a_r10_never_empty: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> first_vld);

    a_r9_lowest_index: assert property (@(posedge clk) disable iff (rst)
        first_vld |-> (st[first_idx] && ((st & ((32'd1 << first_idx) - 32'd1)) == 32'd0)));

    for (genvar i = 0; i < NEDGE; i++) begin : g_hold
        a_r4_pend_holds: assert property (@(posedge clk) disable iff (rst)
            (st[i] && !cfg_we) |=> st[i]);
    end
endmodule

bind wk_cascade wk_cascade_chk #(.NUM_GPIO(NUM_GPIO)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .wake_req  (wake_req),
    .stat_lo   (stat_lo),
    .stat_hi   (stat_hi),
    .first_idx (first_idx),
    .first_vld (first_vld)
);

// File: tb/wk_cascade_tb.sv
`timescale 1ns/1ps
module wk_cascade_tb;
    import wk_pkg::*;
    localparam int NG = 22;
    localparam int NL = 8;
    localparam int NE = NUM_DED + NG;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    ded_src = '0;
    logic [NG-1:0] gpio_src = '0;
    logic [NL-1:0] lvl_src = '1;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [15:0]   cfg_wdata = '0;
    logic          wake_req, first_vld;
    logic [15:0]   stat_lo, stat_hi;
    logic [4:0]    first_idx;

    logic [NE-1:0] m_mask, m_fall, m_pend, m_prev;
    logic [NL-1:0] m_lmask, m_lpol;
    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    wk_cascade #(.NUM_GPIO(NG), .NUM_LVL(NL)) u_dut (
        .clk(clk), .rst(rst), .ded_src(ded_src), .gpio_src(gpio_src),
        .lvl_src(lvl_src), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .wake_req(wake_req), .stat_lo(stat_lo),
        .stat_hi(stat_hi), .first_idx(first_idx), .first_vld(first_vld)
    );

    function automatic logic [7:0] pin_adr(int p);
        return 8'(ADR_PIN_BASE + PIN_STRIDE * p);
    endfunction

    task automatic model_edge();
        logic [NE-1:0] s, clr, hit;
        s   = {gpio_src, ded_src};
        clr = '0;
        if (rst) begin
            m_mask = '1; m_fall = '0; m_pend = '0; m_prev = '0;
            m_lmask = '1; m_lpol = '0;
            return;
        end
        if (cfg_we) begin
            if (cfg_addr == ADR_DED_CLR) clr[1:0] = cfg_wdata[1:0];
            for (int p = 0; p < NG; p++)
                if (cfg_addr == pin_adr(p)) clr[2+p] = cfg_wdata[PIN_CLR_BIT];
        end
        for (int i = 0; i < NE; i++)
            hit[i] = m_fall[i] ? (m_prev[i] & ~s[i]) : (~m_prev[i] & s[i]);
        m_pend = hit | (m_pend & ~clr);
        m_prev = s;
        if (cfg_we) begin
            if (cfg_addr == ADR_DED_MASK) m_mask[1:0] = cfg_wdata[1:0];
            if (cfg_addr == ADR_DED_EDGE) m_fall[1:0] = cfg_wdata[1:0];
            if (cfg_addr == ADR_LVL_MASK) m_lmask = cfg_wdata[NL-1:0];
            if (cfg_addr == ADR_LVL_POL)  m_lpol  = cfg_wdata[NL-1:0];
            for (int p = 0; p < NG; p++)
                if (cfg_addr == pin_adr(p)) begin
                    m_mask[2+p] = cfg_wdata[PIN_MASK_BIT];
                    m_fall[2+p] = cfg_wdata[PIN_FALL_BIT];
                end
        end
    endtask

    function automatic logic [31:0] exp_stat();
        logic [31:0] e;
        e = '0;
        e[NE-1:0]  = m_pend & ~m_mask;
        e[NE+:NL]  = (lvl_src ^ m_lpol) & ~m_lmask;
        return e;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [31:0] e;
        logic [4:0]  ei;
        e  = exp_stat();
        ei = '0;
        for (int i = 31; i >= 0; i--) if (e[i]) ei = 5'(i);
        check("R7", {stat_hi, stat_lo}, e, "status");
        check("R8", 32'(wake_req), 32'(|e), "wake_req");
        check("R9", 32'(first_vld), 32'(|e), "first_vld");
        check("R9", 32'(first_idx), 32'(ei), "first_idx");
        if (wake_req) check("R10", 32'(first_vld), 32'd1, "request without source");
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        cfg_we = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
    endtask

    task automatic chk_bit(string tag, int idx, logic exp);
        logic [31:0] st;
        st = {stat_hi, stat_lo};
        check(tag, 32'(st[idx]), 32'(exp), "status bit");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] snap;
        int unsigned r;
        r = $urandom(32'd1357);
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1: all masked, level inputs high but hidden
        check("R1", {stat_hi, stat_lo}, 32'd0, "reset status");
        check("R1", 32'(wake_req), 32'd0, "reset request");
        lvl_src = '0;

        // R2 / R4: dedicated source 0, rising
        wr(ADR_DED_MASK, 16'h0000);
        ded_src[0] = 1'b1; tick();
        chk_bit("R4", 0, 1'b1);
        ded_src[0] = 1'b0; tick();
        chk_bit("R11", 0, 1'b1);         // falling transition ignored, flag held
        wr(ADR_DED_CLR, 16'h0001);
        chk_bit("R2", 0, 1'b0);

        // R4: captured while masked, revealed on unmask
        wr(ADR_DED_MASK, 16'h0002);
        ded_src[1] = 1'b1; tick();
        chk_bit("R4", 1, 1'b0);
        wr(ADR_DED_MASK, 16'h0000);
        chk_bit("R4", 1, 1'b1);
        wr(ADR_DED_CLR, 16'h0002);
        chk_bit("R2", 1, 1'b0);

        // R2: falling select on source 1
        wr(ADR_DED_EDGE, 16'h0002);
        ded_src[1] = 1'b0; tick();
        chk_bit("R2", 1, 1'b1);
        wr(ADR_DED_CLR, 16'h0002);

        // R5: clear and edge in the same cycle on pin 0 (source 2)
        wr(pin_adr(0), 16'h0000);
        gpio_src[0] = 1'b1;
        cfg_we = 1'b1; cfg_addr = pin_adr(0); cfg_wdata = 16'(1 << PIN_CLR_BIT);
        tick();
        chk_bit("R5", 2, 1'b1);
        wr(pin_adr(0), 16'(1 << PIN_CLR_BIT));
        chk_bit("R3", 2, 1'b0);

        // R3: pin 5 (source 7) falling, then masked through its word
        wr(pin_adr(5), 16'(1 << PIN_FALL_BIT));
        gpio_src[5] = 1'b1; tick();
        chk_bit("R3", 7, 1'b0);
        gpio_src[5] = 1'b0; tick();
        chk_bit("R3", 7, 1'b1);
        wr(pin_adr(5), 16'((1 << PIN_MASK_BIT) | (1 << PIN_FALL_BIT)));
        chk_bit("R3", 7, 1'b0);

        // R6: level polarity
        wr(ADR_LVL_POL, 16'h0002);
        wr(ADR_LVL_MASK, 16'h0000);
        lvl_src = 8'h01; tick();
        chk_bit("R6", NE, 1'b1);
        chk_bit("R6", NE + 1, 1'b1);
        lvl_src = 8'h02; tick();
        chk_bit("R6", NE, 1'b0);
        chk_bit("R6", NE + 1, 1'b0);

        // R9: lowest index wins
        lvl_src = 8'h01; tick();
        check("R9", 32'(first_idx), 32'(NE), "lowest is level");
        ded_src[0] = 1'b1; tick();
        check("R9", 32'(first_idx), 32'd0, "lowest is source 0");
        check("R10", 32'(first_vld), 32'd1, "valid with request");

        // R11: unmapped writes change nothing
        snap = {stat_hi, stat_lo};
        wr(8'h3C, 16'hFFFF);
        wr(8'h42, 16'hFFFF);
        wr(8'h14, 16'hFFFF);
        check("R11", {stat_hi, stat_lo}, snap, "after unmapped writes");

        // constrained random
        for (int k = 0; k < 3000; k++) begin
            r = $urandom;
            if (r[1:0] == 2'd0) ded_src[r[2]] = ~ded_src[r[2]];
            if (r[4:3] == 2'd0) gpio_src[r[9:5] % NG] = ~gpio_src[r[9:5] % NG];
            if (r[12:11] == 2'd0) lvl_src[r[15:13]] = ~lvl_src[r[15:13]];
            if (r[18:16] < 3'd3) begin
                cfg_we = 1'b1;
                cfg_wdata = 16'($urandom);
                case ($urandom % 8)
                    0: cfg_addr = ADR_DED_MASK;
                    1: cfg_addr = ADR_DED_EDGE;
                    2: cfg_addr = ADR_DED_CLR;
                    3: cfg_addr = ADR_LVL_MASK;
                    4: cfg_addr = ADR_LVL_POL;
                    5: cfg_addr = 8'h3C;
                    default: cfg_addr = pin_adr(int'($urandom % NG));
                endcase
            end
            tick();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule